// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions from a small register port toward an external PHY. Software sets a clock divisor and a preamble-skip flag in a configuration register. For a write it loads a 16-bit data value first. It then writes a command word that holds the opcode, the PHY address and the register number. That command write starts the serial transaction. Software polls a busy flag until it clears, and after a read it fetches the returned value from the data register.

The management clock is produced by dividing the system clock. The serial data line is driven through an output and an enable, so a pad or a tristate cell outside the block can merge it with the input. The outgoing bits change while the management clock is low. Incoming read bits are taken when that clock rises. When the skip flag is clear, every access begins with a run of 32 ones. When it is set, the access begins directly with the start pattern. Both the divisor and the flag are captured when a transaction starts, so software may change them between accesses.

Top module: `mdio_manager`

## Requirements
- R1: After reset the configuration register (address 0) reads divisor 32 in bits 7:0 and the preamble-skip flag (bit 8) clear. The status register (address 3, bit 0 = busy) reads 0, the data register (address 1) and the command register (address 2) read 0, MDC is low and the MDIO output enable is low.
- R2: The command register (address 2) holds the register number in bits 4:0, the PHY address in bits 9:5 and the opcode in bits 11:10 (01 = write, 10 = read). Writing it while idle stores it, and busy reads 1 from the next cycle on.
- R3: With the skip flag clear, a transaction shifts out 32 ones followed by the 32-bit frame, 64 MDC periods in all.
- R4: With the skip flag set, the transaction begins directly with the start bits 01 and lasts 32 MDC periods. Clearing the flag again restores the preamble on the next access.
- R5: A write frame is, first bit first: 01, 01, PHY address MSB first, register number MSB first, turnaround 10, then the 16 data bits MSB first. The output enable is high for every bit of the transaction.
- R6: A read frame sends 01, 10, the PHY address and the register number. From the first turnaround bit to the end, the output enable is low. The 16 data bits are taken MSB first on rising MDC, and the resulting value is readable at address 1 once busy is 0.
- R7: One MDC period lasts d system cycles, where d is the divisor, and MDC is high for the last d - floor(d/2) of them. A divisor of 0 or 1 acts as 2.
- R8: MDIO output and output enable change only at a falling MDC edge and stay constant while MDC is high.
- R9: Busy stays 1 for exactly (number of bits) × d system cycles and falls on the same cycle as the last falling MDC edge.
- R10: A command write while busy is ignored. The stored command, the frame in progress and the busy duration are unchanged.
- R11: Whenever busy is 0, MDC is low and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Register write address (0 config, 1 data, 2 command) |
| regWrData | input | 32 | Register write value |
| regRdAddr | input | 2 | Register read address (0 config, 1 data, 2 command, 3 status) |
| regRdData | output | 32 | Combinational read value |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for mdioOut |
| mdioIn | input | 1 | Serial data seen on the line |

## Verification
A wrong bit counter or phase counter shows at the ports within one transaction. The frame gains or loses MDC periods, or busy stays up for a different number of cycles, so a single access exposes it. A misplaced shift or capture shows as a wrong bit at a known position on MDIO, or as a shifted read value as soon as busy clears. A stale divisor or a stale skip flag shows in the very first MDC period of the next access. The bench sweeps divisors, both opcodes, both preamble modes and all PHY addresses, and compares every recorded MDC edge with a frame built arithmetically.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  // Register map of the port
  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_CMD  = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  // Clause-22 frame constants
  localparam int        FRAME_BITS = 32;
  localparam int        TA_FIRST   = 14;  // first turnaround bit index
  localparam int        DATA_FIRST = 16;  // first data bit index
  localparam int        CMD_W      = 12;
  localparam logic [1:0] OP_WRITE  = 2'b01;
  localparam logic [1:0] OP_READ   = 2'b10;
  localparam logic [1:0] START_PAT = 2'b01;
  localparam logic [1:0] TA_WRITE  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FRAME = 2'd2
  } mdioPhase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;      // capture command into frame shifter
    logic       advance;   // step to next frame bit (falling MDC)
    logic       sample;    // take mdioIn (rising MDC)
    logic       finish;    // last falling edge of the frame
    logic       inPre;     // preamble bits in progress
    logic [4:0] frameIdx;  // current frame bit index
  } mdioStrobe_t;

endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdGo,
  input  logic             suppress,
  input  logic [DIV_W-1:0] divisor,
  output logic             mdc,
  output logic             busy,
  output mdioStrobe_t      strb
);

  localparam int SPAN  = (PRE_LEN > FRAME_BITS) ? PRE_LEN : FRAME_BITS;
  localparam int BIT_W = $clog2(SPAN);

  mdioPhase_e       state;
  logic [DIV_W-1:0] phaseCnt;
  logic [DIV_W-1:0] lowQ, highQ;
  logic [BIT_W-1:0] bitCnt;

  logic [DIV_W-1:0] effDiv, lowLen, highLen;
  logic             lastBit, endLow, endHigh;

  // Divisor below two still gives one low and one high cycle
  always_comb begin
    effDiv  = (divisor < DIV_W'(2)) ? DIV_W'(2) : divisor;
    lowLen  = effDiv >> 1;
    highLen = effDiv - lowLen;
  end

  always_comb begin
    if (state == ST_PRE) lastBit = (bitCnt == BIT_W'(PRE_LEN - 1));
    else                 lastBit = (bitCnt == BIT_W'(FRAME_BITS - 1));
    endLow  = (state != ST_IDLE) && !mdc && (phaseCnt == lowQ - DIV_W'(1));
    endHigh = (state != ST_IDLE) &&  mdc && (phaseCnt == highQ - DIV_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      mdc      <= 1'b0;
      phaseCnt <= '0;
      bitCnt   <= '0;
      lowQ     <= DIV_W'(1);
      highQ    <= DIV_W'(1);
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdGo) begin
            state    <= suppress ? ST_FRAME : ST_PRE;
            busy     <= 1'b1;
            mdc      <= 1'b0;
            phaseCnt <= '0;
            bitCnt   <= '0;
            lowQ     <= lowLen;
            highQ    <= highLen;
          end
        end
        default: begin
          if (endLow) begin
            mdc      <= 1'b1;
            phaseCnt <= '0;
          end else if (endHigh) begin
            mdc      <= 1'b0;
            phaseCnt <= '0;
            if (lastBit) begin
              bitCnt <= '0;
              if (state == ST_PRE) begin
                state <= ST_FRAME;
              end else begin
                state <= ST_IDLE;
                busy  <= 1'b0;
              end
            end else begin
              bitCnt <= bitCnt + BIT_W'(1);
            end
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = (state == ST_IDLE) && cmdGo;
    strb.advance  = endHigh && (state == ST_FRAME);
    strb.sample   = (state == ST_FRAME) && mdc && (phaseCnt == '0);
    strb.finish   = endHigh && (state == ST_FRAME) && lastBit;
    strb.inPre    = (state == ST_PRE);
    strb.frameIdx = 5'(bitCnt);
  end

  // R9: busy only drops together with the final falling MDC edge
  a_r9_busy_ends_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $fell(mdc));

  // R11: no clock toggling outside a transaction
  a_r11_idle_mdc_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc);

  // R7: a rising MDC edge only happens inside a transaction
  a_r7_rise_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);

endmodule

// File: rtl/mdio_mgmt_datapath.sv
module mdio_mgmt_datapath
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int DIV_W       = 8,
  parameter int DIV_DEFAULT = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [BUS_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [BUS_W-1:0] rdData,
  input  logic             busy,
  input  mdioStrobe_t      strb,
  input  logic             mdioIn,
  output logic             mdioOut,
  output logic             mdioOe,
  output logic             cmdGo,
  output logic             suppress,
  output logic [DIV_W-1:0] divisor
);

  logic [DIV_W-1:0]      divReg;
  logic                  supReg;
  logic [15:0]           dataReg;
  logic [CMD_W-1:0]      cmdReg;
  logic [FRAME_BITS-1:0] frameReg;
  logic                  isReadQ;
  logic [15:0]           capShift;
  logic [1:0]            newOp;
  logic [1:0]            newTa;
  logic                  released;

  assign cmdGo    = wrEn && (wrAddr == REG_CMD) && !busy;
  assign suppress = supReg;
  assign divisor  = divReg;
  assign newOp    = wrData[11:10];
  assign newTa    = (newOp == OP_READ) ? 2'b00 : TA_WRITE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg   <= DIV_W'(DIV_DEFAULT);
      supReg   <= 1'b0;
      dataReg  <= '0;
      cmdReg   <= '0;
      frameReg <= '0;
      isReadQ  <= 1'b0;
      capShift <= '0;
    end else begin
      if (wrEn && (wrAddr == REG_CFG)) begin
        divReg <= wrData[DIV_W-1:0];
        supReg <= wrData[DIV_W];
      end
      if (wrEn && (wrAddr == REG_DATA)) dataReg <= wrData[15:0];
      if (cmdGo) cmdReg <= wrData[CMD_W-1:0];
      if (strb.load) begin
        frameReg <= {START_PAT, newOp, wrData[9:5], wrData[4:0], newTa, dataReg};
        isReadQ  <= (newOp == OP_READ);
      end else if (strb.advance) begin
        frameReg <= frameReg << 1;
      end
      if (strb.sample && isReadQ && (strb.frameIdx >= 5'(DATA_FIRST)))
        capShift <= {capShift[14:0], mdioIn};
      // Returned value lands when the frame closes
      if (strb.finish && isReadQ)
        dataReg <= strb.sample ? {capShift[14:0], mdioIn} : capShift;
    end
  end

  always_comb begin
    released = isReadQ && !strb.inPre && (strb.frameIdx >= 5'(TA_FIRST));
    mdioOe   = busy && !released;
    if (!busy || strb.inPre) mdioOut = 1'b1;
    else                     mdioOut = frameReg[FRAME_BITS-1];
  end

  always_comb begin
    case (rdAddr)
      REG_CFG:  rdData = BUS_W'({supReg, divReg});
      REG_DATA: rdData = BUS_W'(dataReg);
      REG_CMD:  rdData = BUS_W'(cmdReg);
      default:  rdData = BUS_W'(busy);
    endcase
  end

  // R10: a command write during a transaction leaves the command untouched
  a_r10_cmd_locked: assert property (@(posedge clk) disable iff (!rstN)
    (busy && wrEn && (wrAddr == REG_CMD)) |=> $stable(cmdReg));

  // R2: an accepted command raises busy on the next cycle
  a_r2_go_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmdGo |=> busy);

  // R11: line released whenever idle
  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

endmodule

// File: rtl/mdio_manager.sv
module mdio_manager
  import mdio_mgmt_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int DIV_W       = 8,
  parameter int DIV_DEFAULT = 32,
  parameter int PRE_LEN     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regWrAddr,
  input  logic [BUS_W-1:0] regWrData,
  input  logic [1:0]       regRdAddr,
  output logic [BUS_W-1:0] regRdData,
  output logic             mdc,
  output logic             mdioOut,
  output logic             mdioOe,
  input  logic             mdioIn
);

  mdioStrobe_t      strb;
  logic             cmdGo, suppress, busy;
  logic [DIV_W-1:0] divisor;

  mdio_mgmt_ctrl #(.DIV_W(DIV_W), .PRE_LEN(PRE_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdGo    (cmdGo),
    .suppress (suppress),
    .divisor  (divisor),
    .mdc      (mdc),
    .busy     (busy),
    .strb     (strb)
  );

  mdio_mgmt_datapath #(.BUS_W(BUS_W), .DIV_W(DIV_W), .DIV_DEFAULT(DIV_DEFAULT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .wrAddr   (regWrAddr),
    .wrData   (regWrData),
    .rdAddr   (regRdAddr),
    .rdData   (regRdData),
    .busy     (busy),
    .strb     (strb),
    .mdioIn   (mdioIn),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .cmdGo    (cmdGo),
    .suppress (suppress),
    .divisor  (divisor)
  );

  // R8: the line holds still while MDC is high
  a_r8_stable_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> ($stable(mdioOut) && $stable(mdioOe)));

endmodule

// File: tb/mdio_manager_tb.sv
module mdio_manager_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdAddr = '0;
  logic [31:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  mdio_manager u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // PHY-side observation state
  int   cycCnt = 0;
  int   nRec = 0;
  int   lastRise = 0;
  bit   haveRise = 1'b0;
  int   perErr = 0;
  int   stabErr = 0;
  int   expDiv = 2;
  int   expHigh = 1;
  int   curPre = 32;
  bit   curRead = 1'b0;
  logic [15:0] curResp = '0;
  logic recOut [0:63];
  logic recOe  [0:63];

  always @(posedge clk) cycCnt++;

  always @(posedge mdc) begin
    if (nRec < 64) begin
      recOut[nRec] = mdioOut;
      recOe[nRec]  = mdioOe;
    end
    if (haveRise && (cycCnt - lastRise != expDiv)) perErr++;
    lastRise = cycCnt;
    haveRise = 1'b1;
  end

  always @(negedge mdc) begin
    if (cycCnt - lastRise != expHigh) perErr++;
    nRec++;
  end

  always @(negedge clk) begin
    if (mdc && nRec < 64)
      if (mdioOut !== recOut[nRec] || mdioOe !== recOe[nRec]) stabErr++;
  end

  // PHY response: data bits after turnaround during a read
  always_comb begin
    int pos;
    pos = nRec - curPre;
    if (curRead && pos >= 16 && pos < 32) mdioIn = curResp[31 - pos];
    else                                  mdioIn = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [31:0] d);
    regRdAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic doTxn(input int div, input bit sup, input logic [1:0] op,
                       input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wdat, input logic [15:0] resp,
                       input bit inject);
    logic [11:0] cmd;
    logic [31:0] frame;
    logic [31:0] rv;
    int busyCycles, nBits, mism, firstBad;
    bit isRd;
    isRd     = (op == 2'b10);
    cmd      = {op, phy, rg};
    frame    = {2'b01, op, phy, rg, (isRd ? 2'b00 : 2'b10), wdat};
    regWrite(2'd0, 32'((sup ? 32'h100 : 32'h0) | 32'(div & 8'hFF)));
    regWrite(2'd1, {16'h0, wdat});
    expDiv   = (div < 2) ? 2 : div;
    expHigh  = expDiv - expDiv / 2;
    curPre   = sup ? 0 : 32;
    curRead  = isRd;
    curResp  = resp;
    nRec     = 0;
    haveRise = 1'b0;
    perErr   = 0;
    stabErr  = 0;
    nBits    = curPre + 32;
    regRdAddr = 2'd3;
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = 2'd2; regWrData = {20'h0, cmd};
    @(negedge clk);
    regWrEn = 1'b0;
    check(regRdData[0] === 1'b1, "R2", "busy after command", regRdData[0], 1);
    busyCycles = 1;
    while (1) begin
      if (inject && busyCycles == 10) begin
        regWrEn = 1'b1; regWrAddr = 2'd2; regWrData = {20'h0, ~cmd};
      end else begin
        regWrEn = 1'b0;
      end
      @(negedge clk);
      if (regRdData[0] !== 1'b1) break;
      busyCycles++;
    end
    regWrEn = 1'b0;
    check(busyCycles == nBits * expDiv, "R9", "busy cycles", busyCycles, nBits * expDiv);
    check(nRec == nBits, sup ? "R4" : "R3", "MDC periods", nRec, nBits);
    mism = 0; firstBad = -1;
    for (int k = 0; k < nBits && k < 64; k++) begin
      logic eOut, eOe;
      int j;
      j = k - curPre;
      if (j < 0) begin eOut = 1'b1; eOe = 1'b1; end
      else begin
        eOut = frame[31 - j];
        eOe  = !(isRd && j >= 14);
      end
      if (recOe[k] !== eOe || (eOe && recOut[k] !== eOut)) begin
        mism++;
        if (firstBad < 0) firstBad = k;
      end
    end
    check(mism == 0, isRd ? "R6" : "R5", "frame bit mismatches (first bad index in msg)",
          mism, 0);
    if (mism != 0) $display("  first mismatch at bit %0d", firstBad);
    check(perErr == 0, "R7", "MDC period errors", perErr, 0);
    check(stabErr == 0, "R8", "MDIO changes while MDC high", stabErr, 0);
    check(mdc === 1'b0 && mdioOe === 1'b0, "R11", "idle mdc/oe", {mdc, mdioOe}, 0);
    regRead(2'd1, rv);
    if (isRd) check(rv[15:0] === resp, "R6", "read data", rv[15:0], resp);
    else      check(rv[15:0] === wdat, "R5", "data reg after write", rv[15:0], wdat);
    regRead(2'd2, rv);
    check(rv[11:0] === cmd, inject ? "R10" : "R2", "command readback", rv[11:0], cmd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int divs [6] = '{0, 1, 2, 3, 4, 7};
    int idx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    regRead(2'd0, rv); check(rv === 32'h20, "R1", "config after reset", rv, 32'h20);
    regRead(2'd3, rv); check(rv === 32'h0, "R1", "status after reset", rv, 0);
    regRead(2'd1, rv); check(rv === 32'h0, "R1", "data after reset", rv, 0);
    regRead(2'd2, rv); check(rv === 32'h0, "R1", "command after reset", rv, 0);
    check(mdc === 1'b0 && mdioOe === 1'b0, "R1", "mdc/oe after reset", {mdc, mdioOe}, 0);

    // Default divisor (32) with preamble, one read and one write
    doTxn(32, 1'b0, 2'b01, 5'd1, 5'd0, 16'hBEEF, 16'h0000, 1'b0);
    doTxn(32, 1'b0, 2'b10, 5'd30, 5'd17, 16'h0000, 16'h8001, 1'b0);

    // Divisor / mode / opcode sweep
    idx = 0;
    foreach (divs[d]) begin
      for (int s = 1; s >= 0; s--) begin
        for (int o = 0; o < 2; o++) begin
          doTxn(divs[d], s[0], (o == 0) ? 2'b01 : 2'b10,
                5'((idx * 7) % 32), 5'((idx * 11 + 3) % 32),
                16'(16'hA5C3 ^ (idx * 16'h0133)), 16'(16'h1234 + idx * 16'h0F0F), 1'b0);
          idx++;
        end
      end
    end

    // Every PHY address, fast clock, preamble skipped
    for (int p = 0; p < 32; p++)
      doTxn(2, 1'b1, (p % 2 == 0) ? 2'b10 : 2'b01, 5'(p), 5'(31 - p),
            16'(p * 16'h0801), 16'(16'hFFFF - p * 16'h0421), 1'b0);

    // R10 ignored command while busy
    doTxn(4, 1'b0, 2'b01, 5'd9, 5'd22, 16'h5A5A, 16'h0, 1'b1);
    doTxn(3, 1'b1, 2'b10, 5'd18, 5'd5, 16'h0, 16'hC3A5, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule